// File: doc/BRIEF.md
# Divide-by-Five Symmetric Clock Generator

This block takes a fast input clock and derives a clock at one fifth of its frequency with equal high and low times. Because five is odd, a divider that works on rising edges alone can only reach a 2:3 or 3:2 split. This block reaches 50% by using both edges of the input clock.

A three-flop feedback counter steps on each rising edge through five legal states. One tapped bit is high for two of the five counts. A second flop copies that bit on each falling edge, so its high interval starts and ends half an input period later. The OR of the tapped bit and its delayed copy is high for two and a half input periods and low for two and a half. The counter state is brought out so that the state walk and its recovery from unused codes can be observed. The value that reset loads is a parameter, so an unused code can be loaded on purpose.

Top module: `div5_clock_divider`

## Requirements
- R1: While `rst` is high, each rising edge of `clk` loads the counter with the `RESET_STATE` parameter (default 000), and each falling edge clears the falling-edge copy. With the default value, `clk_out` is low while reset is held.
- R2: `state` is written as {Q2,Q1,Q0}. From reset, the counter steps once per rising edge through 000, 001, 011, 110, 100 and then back to 000.
- R3: Unused code 101 steps to 010 and then to 100. It reaches the legal cycle after two rising edges.
- R4: Unused code 010 steps to 100, and unused code 111 steps to 110. Each reaches the legal cycle after one rising edge.
- R5: The tapped bit (Q0 by default) is high for exactly two of every five consecutive counts in the legal cycle.
- R6: In the legal cycle, `clk_out` is high for exactly five input half-periods and then low for exactly five. It changes level exactly twice in every ten half-periods.
- R7: `clk_out` rises at the rising edge of `clk` on which the tapped bit rises. It falls at the falling edge of `clk` that follows the rising edge on which the tapped bit falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| clk_out | output | 1 | Divided clock at one fifth of the input rate, 50% duty |
| state | output | 3 | Counter bits {Q2,Q1,Q0} for observation |

## Verification
Two things can happen in the same cycle: the counter leaves an unused code, and the reset that loaded that code is released. The bench sets this up with extra instances that reset into 101, 010 and 111, releases reset for all of them together, and compares each state against the exact recovery path and then the legal walk. The tap falling at a rising edge while the falling-edge copy still holds high is the other shared moment. It is judged by sampling `clk_out` in every half-period and comparing against a computed five-high, five-low pattern.

// File: rtl/div5_pkg.sv
`timescale 1ns/1ps
package div5_pkg;
  localparam int CNT_W = 3;
  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t ST_IDLE = 3'b000;
  localparam cnt_t ST_LEAD = 3'b001;
  localparam cnt_t ST_PAIR = 3'b011;
  localparam cnt_t ST_FALL = 3'b110;
  localparam cnt_t ST_TAIL = 3'b100;

  function automatic logic in_cycle(input cnt_t s);
    return (s == ST_IDLE) || (s == ST_LEAD) || (s == ST_PAIR) ||
           (s == ST_FALL) || (s == ST_TAIL);
  endfunction
endpackage

// File: rtl/div5_ring_counter.sv
`timescale 1ns/1ps
module div5_ring_counter
  import div5_pkg::*;
#(
  parameter cnt_t RESET_STATE = ST_IDLE
) (
  input  logic clk,
  input  logic rst,
  output cnt_t cnt
);
  cnt_t cnt_nxt;

  // Q0 is set only when both upper bits are clear; the other bits shift up
  always_comb begin
    cnt_nxt[0] = ~cnt[1] & ~cnt[2];
    cnt_nxt[1] = cnt[0];
    cnt_nxt[2] = cnt[1];
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= RESET_STATE;
    else     cnt <= cnt_nxt;
  end
endmodule

// File: rtl/div5_fall_stage.sv
`timescale 1ns/1ps
module div5_fall_stage (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(negedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/div5_phase_or.sv
`timescale 1ns/1ps
module div5_phase_or (
  input  logic lead,
  input  logic lag,
  output logic merged
);
  // lead falls only while lag is high, so the handover leaves no gap
  assign merged = lead | lag;
endmodule

// File: rtl/div5_clock_divider.sv
`timescale 1ns/1ps
module div5_clock_divider
  import div5_pkg::*;
#(
  parameter cnt_t RESET_STATE = ST_IDLE,
  parameter int   TAP_BIT     = 0
) (
  input  logic             clk,
  input  logic             rst,
  output logic             clk_out,
  output logic [CNT_W-1:0] state
);
  cnt_t cnt;
  logic tap;
  logic tap_late;

  div5_ring_counter #(.RESET_STATE(RESET_STATE)) u_cnt (
    .clk (clk),
    .rst (rst),
    .cnt (cnt)
  );

  assign tap = cnt[TAP_BIT];

  div5_fall_stage u_fall (
    .clk (clk),
    .rst (rst),
    .d   (tap),
    .q   (tap_late)
  );

  div5_phase_or u_or (
    .lead   (tap),
    .lag    (tap_late),
    .merged (clk_out)
  );

  assign state = cnt;
endmodule

// File: rtl/div5_checker.sv
`timescale 1ns/1ps
module div5_checker
  import div5_pkg::*;
#(
  parameter cnt_t RESET_STATE = ST_IDLE,
  parameter int   TAP_BIT     = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             clk_out,
  input logic [CNT_W-1:0] state
);
  a_r1_reset_load: assert property (@(posedge clk)
    rst |=> state == RESET_STATE);

  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    state == ST_TAIL |=> state == ST_IDLE);

  a_r2_closed: assert property (@(posedge clk) disable iff (rst)
    in_cycle(state) |=> in_cycle(state));

  a_r3_from_101: assert property (@(posedge clk) disable iff (rst)
    state == 3'b101 |=> state == 3'b010);

  a_r4_one_step: assert property (@(posedge clk) disable iff (rst)
    (state == 3'b010 || state == 3'b111) |=> in_cycle(state));

  a_r5_two_high: assert property (@(posedge clk) disable iff (rst)
    $rose(state[TAP_BIT]) |=> state[TAP_BIT] ##1 !state[TAP_BIT]);

  a_r7_late_half: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> clk_out == state[TAP_BIT]);
endmodule

bind div5_clock_divider div5_checker #(
  .RESET_STATE (RESET_STATE),
  .TAP_BIT     (TAP_BIT)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .clk_out (clk_out),
  .state   (state)
);

// File: tb/div5_clock_divider_test.sv
`timescale 1ns/1ps
module div5_clock_divider_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic       o_a, o_b, o_c, o_d;
  logic [2:0] s_a, s_b, s_c, s_d;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  div5_clock_divider uut (.clk(clk), .rst(rst), .clk_out(o_a), .state(s_a));
  div5_clock_divider #(.RESET_STATE(3'b101)) u101 (.clk(clk), .rst(rst), .clk_out(o_b), .state(s_b));
  div5_clock_divider #(.RESET_STATE(3'b010)) u010 (.clk(clk), .rst(rst), .clk_out(o_c), .state(s_c));
  div5_clock_divider #(.RESET_STATE(3'b111)) u111 (.clk(clk), .rst(rst), .clk_out(o_d), .state(s_d));

  function automatic logic [2:0] walk(input int i);
    case (i % 5)
      0: return 3'b000;
      1: return 3'b001;
      2: return 3'b011;
      3: return 3'b110;
      default: return 3'b100;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int hi_run;
    int edges;
    logic prev;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(s_a == 3'b000, "R1 reset state", s_a, 0);
    check(o_a == 1'b0, "R1 clk_out low in reset", o_a, 0);
    check(s_b == 3'b101, "R1 reset loads 101", s_b, 5);
    check(s_c == 3'b010, "R1 reset loads 010", s_c, 2);
    check(s_d == 3'b111, "R1 reset loads 111", s_d, 7);
    @(posedge clk); #1 rst = 1'b0;

    hi_run = 0;
    edges = 0;
    prev = 1'b0;
    for (int i = 0; i < 250; i++) begin
      logic exp_o;
      if (i % 2 == 0) begin
        int k;
        @(posedge clk); #1;
        k = i / 2 + 1;
        check(s_a == walk(k), "R2 legal walk", s_a, walk(k));
        if (k == 1) check(s_b == 3'b010, "R3 101 first step", s_b, 2);
        else        check(s_b == walk(k + 2), "R3 101 recovery", s_b, walk(k + 2));
        check(s_c == walk(k + 3), "R4 010 recovery", s_c, walk(k + 3));
        check(s_d == walk(k + 2), "R4 111 recovery", s_d, walk(k + 2));
        if (s_a[0]) hi_run++;
        if (k % 5 == 0) begin
          check(hi_run == 2, "R5 tap two of five", hi_run, 2);
          hi_run = 0;
        end
      end else begin
        @(negedge clk); #1;
      end
      exp_o = ((i % 10) < 5);
      check(o_a == exp_o, "R6 R7 clk_out half-period pattern", o_a, exp_o);
      if (o_a != prev) edges++;
      prev = o_a;
      if (i % 10 == 9) begin
        check(edges == 2, "R6 two transitions per period", edges, 2);
        edges = 0;
      end
    end

    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1;
    check(s_a == 3'b000, "R1 mid-run reset state", s_a, 0);
    @(negedge clk); #1;
    check(o_a == 1'b0, "R1 mid-run reset clk_out", o_a, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule